// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block moves data between system memory and a card data path by walking a table of 8-byte descriptors held in memory. Software loads a table base address and selects descriptor-chained DMA. A command with DMA enabled then starts the engine. The engine reads each descriptor as two 32-bit words and decodes its attribute byte. It then either moves the given number of bytes, skips the entry, or jumps to another table. It stops after the entry flagged as the last one.

Data moves one byte at a time. When data flows from the card into memory, bytes taken from an input stream become byte writes to ascending addresses. When data flows from memory to the card, byte reads from ascending addresses feed an output stream. Completion and descriptor errors are held in sticky status flags, which a one-cycle clear pulse resets. A pulse marks each descriptor that asked for an interrupt.

Top module: `chain_desc_dma`

## Requirements
- R1: After reset, busy, done_flag, err_flag, irq, desc_int, mem_req, in_ready and out_valid are all 0.
- R2: A start pulse launches a walk only when cfg_mode equals 2, cfg_master_en is 1 and xfer_dma_en is 1. Otherwise the engine issues no memory request and busy stays 0.
- R3: The first descriptor is at the base register with its low 3 bits cleared, and each next one is 8 bytes further on. A descriptor is fetched as two 32-bit word reads (mem_word=1), first at its address and then at address+4. A request stays asserted with a stable address until mem_ack.
- R4: Fields are little-endian. Word 0 bits 7:0 hold the attribute and bits 31:16 the byte length; word 1 holds the address. Attribute bit 0 is valid, bit 1 is last, bit 2 is interrupt request and bits 5:4 are the action. Action 2'b10 moves length bytes at ascending addresses starting at the address field. A length of 0, and action codes 00 and 01, move nothing.
- R5: With xfer_to_mem=1, bytes accepted on in_data (in_valid and in_ready) are written to memory in order. With xfer_to_mem=0, bytes read from memory appear on out_data, in order, one per out_valid/out_ready handshake.
- R6: Action 2'b11 is a link: the next descriptor is fetched at the address field with its low 3 bits cleared. The last bit of a link entry is ignored.
- R7: After the last descriptor's data has moved, done_flag is set and busy drops. done_flag stays set until a clr_done pulse.
- R8: A fetched descriptor with the valid bit clear stops the walk and sets err_flag without setting done_flag. Its address is captured on err_addr. err_flag stays set until a clr_err pulse, and irq equals err_flag AND err_ie.
- R9: desc_int pulses for one cycle when a valid non-link descriptor whose interrupt-request bit is set retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base_we | input | 1 | Write strobe for the table base register |
| cfg_base_wdata | input | AW | Table base address |
| cfg_mode | input | 2 | DMA mode select; 2 selects descriptor chaining |
| cfg_master_en | input | 1 | Master DMA enable |
| err_ie | input | 1 | Interrupt enable for the error flag |
| xfer_start | input | 1 | Command issue pulse |
| xfer_dma_en | input | 1 | DMA enable carried by the command |
| xfer_to_mem | input | 1 | 1: card to memory, 0: memory to card |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a byte write |
| mem_word | output | 1 | Request is a 32-bit word read |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data (a byte read uses bits 7:0) |
| in_valid | input | 1 | Card-side byte available |
| in_data | input | 8 | Card-side byte |
| in_ready | output | 1 | Engine takes a card-side byte |
| out_valid | output | 1 | Byte available toward the card |
| out_data | output | 8 | Byte toward the card |
| out_ready | input | 1 | Card side takes the byte |
| busy | output | 1 | A walk is in progress |
| desc_int | output | 1 | Interrupt-request descriptor retired |
| done_flag | output | 1 | Sticky transfer-complete flag |
| err_flag | output | 1 | Sticky descriptor error flag |
| err_addr | output | AW | Address of the failing descriptor |
| irq | output | 1 | Enabled error interrupt |
| clr_done | input | 1 | Clear pulse for done_flag |
| clr_err | input | 1 | Clear pulse for err_flag |

## Verification
The bench places the base at a misaligned address and points a link entry at a misaligned target. An engine that did not clear the low bits would fetch garbage and raise an error. It walks through a link entry that also carries the last bit, a no-action entry and a zero-length data entry. An engine that stopped on the link, or moved bytes for the other two, would produce unexpected writes or a missing completion. It stalls both streams during transfers to catch bytes that are dropped or repeated when a handshake is held off. An invalid entry placed after a good one checks that the error reports the second descriptor's address rather than the first, and that completion is not set. The start gating is tried with each of the three enables removed in turn; an engine that ignored one of them would issue memory requests.

// File: rtl/cdd_pkg.sv
package cdd_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH0,
      S_FETCH1,
      S_DECODE,
      S_MOVE,
      S_PUSH,
      S_RETIRE
   } cdd_state_t;

   typedef struct packed {
      logic        valid;
      logic        last;
      logic        irq_req;
      logic [1:0]  act;
      logic [15:0] len;
      logic [31:0] addr;
   } cdd_desc_t;

   localparam logic [1:0] ACT_DATA   = 2'b10;
   localparam logic [1:0] ACT_LINK   = 2'b11;
   localparam logic [1:0] MODE_CHAIN = 2'd2;

endpackage

// File: rtl/cdd_desc_unpack.sv
module cdd_desc_unpack
   import cdd_pkg::*;
#(
   parameter bit LITTLE = 1'b1
) (
   input  logic [31:0] word0,
   input  logic [31:0] word1,
   output cdd_desc_t   desc
);

   logic [7:0]  attr;
   logic [15:0] len;
   logic [31:0] addr;

   generate
      if (LITTLE) begin : g_le
         assign attr = word0[7:0];
         assign len  = word0[31:16];
         assign addr = word1;
      end else begin : g_be
         assign attr = word0[31:24];
         assign len  = {word0[7:0], word0[15:8]};
         assign addr = {word1[7:0], word1[15:8], word1[23:16], word1[31:24]};
      end
   endgenerate

   always_comb begin
      desc.valid   = attr[0];
      desc.last    = attr[1];
      desc.irq_req = attr[2];
      desc.act     = attr[5:4];
      desc.len     = len;
      desc.addr    = addr;
   end

endmodule

// File: rtl/cdd_status.sv
module cdd_status #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_done,
   input  logic          set_err,
   input  logic [AW-1:0] err_addr_in,
   input  logic          clr_done,
   input  logic          clr_err,
   input  logic          err_ie,
   output logic          done_flag,
   output logic          err_flag,
   output logic [AW-1:0] err_addr,
   output logic          irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_flag <= 1'b0;
         err_flag  <= 1'b0;
         err_addr  <= '0;
      end else begin
         if (set_done)      done_flag <= 1'b1;
         else if (clr_done) done_flag <= 1'b0;
         if (set_err) begin
            err_flag <= 1'b1;
            err_addr <= err_addr_in;
         end else if (clr_err) begin
            err_flag <= 1'b0;
         end
      end
   end

   assign irq = err_flag & err_ie;

   // R7: completion holds until cleared
   p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_flag && !clr_done |=> done_flag);

   // R8: error holds until cleared, captured address holds with it
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag && !clr_err |=> err_flag);

   p_erraddr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag && !set_err |=> $stable(err_addr));

endmodule

// File: rtl/chain_desc_dma.sv
module chain_desc_dma
   import cdd_pkg::*;
#(
   parameter int AW           = 32,
   parameter bit LITTLE_FETCH = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_base_we,
   input  logic [AW-1:0] cfg_base_wdata,
   input  logic [1:0]    cfg_mode,
   input  logic          cfg_master_en,
   input  logic          err_ie,
   input  logic          xfer_start,
   input  logic          xfer_dma_en,
   input  logic          xfer_to_mem,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_word,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   input  logic          in_valid,
   input  logic [7:0]    in_data,
   output logic          in_ready,
   output logic          out_valid,
   output logic [7:0]    out_data,
   input  logic          out_ready,
   output logic          busy,
   output logic          desc_int,
   output logic          done_flag,
   output logic          err_flag,
   output logic [AW-1:0] err_addr,
   output logic          irq,
   input  logic          clr_done,
   input  logic          clr_err
);

   localparam int            LW          = 16;
   localparam logic [AW-1:0] DESC_STRIDE = AW'(8);
   localparam logic [AW-1:0] WORD_STEP   = AW'(4);
   localparam logic [AW-1:0] ALIGN_MASK  = ~AW'(7);
   localparam logic [LW-1:0] LEN_ONE     = LW'(1);

   initial begin
      if (AW < 16 || AW > 32) $fatal(1, "chain_desc_dma: AW must be 16..32");
   end

   cdd_state_t    st;
   logic [AW-1:0] base_q, cur_q, ptr_q;
   logic [LW-1:0] rem_q;
   logic [31:0]   w0_q, w1_q;
   logic [7:0]    hold_q;
   logic          dir_q;
   cdd_desc_t     dsc;
   logic          go, byte_done, take_byte, set_done, set_err;
   logic [AW-1:0] link_tgt;

   cdd_desc_unpack #(.LITTLE(LITTLE_FETCH)) u_unpack (
      .word0 (w0_q),
      .word1 (w1_q),
      .desc  (dsc)
   );

   assign link_tgt  = dsc.addr[AW-1:0] & ALIGN_MASK;
   assign go        = (st == S_IDLE) && xfer_start && xfer_dma_en &&
                      (cfg_mode == MODE_CHAIN) && cfg_master_en;
   assign take_byte = (st == S_MOVE) && (dir_q ? in_valid : mem_ack);
   assign byte_done = (st == S_PUSH) && (dir_q ? mem_ack : out_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         base_q <= '0;
         cur_q  <= '0;
         ptr_q  <= '0;
         rem_q  <= '0;
         w0_q   <= '0;
         w1_q   <= '0;
         hold_q <= '0;
         dir_q  <= 1'b0;
      end else begin
         if (cfg_base_we) base_q <= cfg_base_wdata;
         case (st)
            S_IDLE: if (go) begin
               cur_q <= base_q & ALIGN_MASK;
               dir_q <= xfer_to_mem;
               st    <= S_FETCH0;
            end
            S_FETCH0: if (mem_ack) begin
               w0_q <= mem_rdata;
               st   <= S_FETCH1;
            end
            S_FETCH1: if (mem_ack) begin
               w1_q <= mem_rdata;
               st   <= S_DECODE;
            end
            S_DECODE: begin
               if (!dsc.valid) begin
                  st <= S_IDLE;
               end else if (dsc.act == ACT_LINK) begin
                  cur_q <= link_tgt;
                  st    <= S_FETCH0;
               end else if (dsc.act == ACT_DATA && dsc.len != '0) begin
                  ptr_q <= dsc.addr[AW-1:0];
                  rem_q <= dsc.len;
                  st    <= S_MOVE;
               end else begin
                  st <= S_RETIRE;
               end
            end
            S_MOVE: if (take_byte) begin
               hold_q <= dir_q ? in_data : mem_rdata[7:0];
               st     <= S_PUSH;
            end
            S_PUSH: if (byte_done) begin
               ptr_q <= ptr_q + AW'(1);
               rem_q <= rem_q - LEN_ONE;
               st    <= (rem_q == LEN_ONE) ? S_RETIRE : S_MOVE;
            end
            S_RETIRE: begin
               if (dsc.last) begin
                  st <= S_IDLE;
               end else begin
                  cur_q <= cur_q + DESC_STRIDE;
                  st    <= S_FETCH0;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_word = (st == S_FETCH0) || (st == S_FETCH1);
      mem_we   = (st == S_PUSH) && dir_q;
      mem_req  = mem_word || mem_we || ((st == S_MOVE) && !dir_q);
      case (st)
         S_FETCH0: mem_addr = cur_q;
         S_FETCH1: mem_addr = cur_q + WORD_STEP;
         default:  mem_addr = ptr_q;
      endcase
   end

   assign mem_wdata = hold_q;
   assign out_data  = hold_q;
   assign in_ready  = (st == S_MOVE) && dir_q;
   assign out_valid = (st == S_PUSH) && !dir_q;
   assign busy      = (st != S_IDLE);
   assign set_err   = (st == S_DECODE) && !dsc.valid;
   assign set_done  = (st == S_RETIRE) && dsc.last;
   assign desc_int  = (st == S_RETIRE) && dsc.irq_req;

   cdd_status #(.AW(AW)) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_done    (set_done),
      .set_err     (set_err),
      .err_addr_in (cur_q),
      .clr_done    (clr_done),
      .clr_err     (clr_err),
      .err_ie      (err_ie),
      .done_flag   (done_flag),
      .err_flag    (err_flag),
      .err_addr    (err_addr),
      .irq         (irq)
   );

   // R3: a pending memory request is held unchanged until accepted
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R2: a walk begins only with all three enables present
   p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cfg_mode) == MODE_CHAIN && $past(cfg_master_en)
                      && $past(xfer_dma_en));

   // R5: only one stream direction is active at a time
   p_one_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));

   // R4: a byte being delivered always belongs to a non-empty count
   p_rem_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_PUSH) |-> rem_q != '0);

   // R8: an error ends the walk at once and never coincides with completion
   p_err_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> !busy && !$rose(done_flag));

endmodule

// File: tb/sim_chain_desc_dma.sv
module sim_chain_desc_dma;

   typedef struct packed {
      logic [31:0] a;
      logic [7:0]  d;
   } wr_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_base_we = 1'b0;
   logic [31:0] cfg_base_wdata = '0;
   logic [1:0]  cfg_mode = 2'd2;
   logic        cfg_master_en = 1'b1;
   logic        err_ie = 1'b0;
   logic        xfer_start = 1'b0;
   logic        xfer_dma_en = 1'b0;
   logic        xfer_to_mem = 1'b0;
   logic        mem_req, mem_we, mem_word;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        out_ready = 1'b0;
   logic        busy, desc_int, done_flag, err_flag, irq;
   logic [31:0] err_addr;
   logic        clr_done = 1'b0;
   logic        clr_err = 1'b0;

   chain_desc_dma u0 (.*);

   always #10 clk = ~clk;

   logic [7:0] mem [0:4095];
   logic [7:0] exp_out[$];
   logic [7:0] in_q[$];
   wr_t        wq[$];
   int         n_chk = 0, n_fail = 0;
   int         cyc = 0, req_cnt = 0, int_cnt = 0, out_cnt = 0, wr_cnt = 0;
   bit         acc = 1'b0, finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic put_desc(input int at, input logic [7:0] attr,
                           input logic [15:0] len, input logic [31:0] addr);
      mem[at]   = attr;
      mem[at+1] = 8'h00;
      mem[at+2] = len[7:0];
      mem[at+3] = len[15:8];
      mem[at+4] = addr[7:0];
      mem[at+5] = addr[15:8];
      mem[at+6] = addr[23:16];
      mem[at+7] = addr[31:24];
   endtask

   task automatic set_base(input logic [31:0] b);
      @(negedge clk);
      cfg_base_we    = 1'b1;
      cfg_base_wdata = b;
      @(negedge clk);
      cfg_base_we    = 1'b0;
   endtask

   task automatic kick(input bit to_mem, input bit dma_en);
      @(negedge clk);
      xfer_start  = 1'b1;
      xfer_dma_en = dma_en;
      xfer_to_mem = to_mem;
      @(negedge clk);
      xfer_start  = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000; i++) begin
         if (!busy) break;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic pulse_clr(input bit which_err);
      @(negedge clk);
      if (which_err) clr_err = 1'b1; else clr_done = 1'b1;
      @(negedge clk);
      clr_err  = 1'b0;
      clr_done = 1'b0;
   endtask

   // memory model, scoreboard monitors and input source
   always @(negedge clk) begin
      cyc++;
      if (desc_int) int_cnt++;
      if (mem_req) begin
         int a;
         a = int'(mem_addr[11:0]);
         req_cnt++;
         mem_ack = 1'b1;
         if (mem_we) begin
            wr_t e;
            mem[a] = mem_wdata;
            wr_cnt++;
            if (wq.size() == 0) begin
               chk(1'b0, "R5", "unexpected write", {mem_addr, mem_wdata}, 0);
            end else begin
               e = wq.pop_front();
               chk(e.a == mem_addr && e.d == mem_wdata, "R5", "write addr/data",
                   {mem_addr, mem_wdata}, {e.a, e.d});
            end
         end else if (mem_word) begin
            mem_rdata = {mem[(a+3)%4096], mem[(a+2)%4096], mem[(a+1)%4096], mem[a]};
         end else begin
            mem_rdata = {24'h0, mem[a]};
         end
      end else begin
         mem_ack = 1'b0;
      end
      out_ready = (cyc % 3) != 0;
      if (out_valid && out_ready) begin
         logic [7:0] e;
         out_cnt++;
         if (exp_out.size() == 0) begin
            chk(1'b0, "R5", "unexpected out byte", out_data, 0);
         end else begin
            e = exp_out.pop_front();
            chk(out_data == e, "R5", "out byte", out_data, e);
         end
      end
      if (acc) void'(in_q.pop_front());
      in_valid = (in_q.size() > 0) && ((cyc % 4) != 1);
      in_data  = (in_q.size() > 0) ? in_q[0] : 8'h00;
      acc      = in_valid && in_ready;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int rc;
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(!busy && !done_flag && !err_flag && !irq && !desc_int, "R1", "status at reset",
          {busy, done_flag, err_flag, irq, desc_int}, 0);
      chk(!mem_req && !in_ready && !out_valid, "R1", "handshakes at reset",
          {mem_req, in_ready, out_valid}, 0);
      rst_n = 1'b1;

      // table A: memory to card, misaligned base, interrupt on first entry
      put_desc(12'h100, 8'h25, 16'd3, 32'h200);
      put_desc(12'h108, 8'h23, 16'd2, 32'h300);
      mem[12'h200] = 8'h11; mem[12'h201] = 8'h22; mem[12'h202] = 8'h33;
      mem[12'h300] = 8'h44; mem[12'h301] = 8'h55;
      exp_out = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      set_base(32'h103);
      int_cnt = 0; out_cnt = 0;
      kick(1'b0, 1'b1);
      chk(busy, "R2", "busy after enabled start", busy, 1);
      wait_idle();
      chk(out_cnt == 5 && exp_out.size() == 0, "R3", "bytes out of chained table",
          out_cnt, 5);
      chk(done_flag && !err_flag, "R7", "done after last entry", {done_flag, err_flag}, 2'b10);
      chk(int_cnt == 1, "R9", "interrupt-request pulses", int_cnt, 1);
      repeat (5) @(negedge clk);
      chk(done_flag, "R7", "done sticky", done_flag, 1);
      pulse_clr(1'b0);
      chk(!done_flag, "R7", "done cleared", done_flag, 0);

      // table B: link with last bit, no-action entry, zero length, card to memory
      put_desc(12'h400, 8'h33, 16'd0, 32'h505);
      put_desc(12'h500, 8'h01, 16'd5, 32'h900);
      put_desc(12'h508, 8'h21, 16'd0, 32'h900);
      put_desc(12'h510, 8'h23, 16'd4, 32'h600);
      in_q = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
      wq.push_back('{a: 32'h600, d: 8'hA1});
      wq.push_back('{a: 32'h601, d: 8'hB2});
      wq.push_back('{a: 32'h602, d: 8'hC3});
      wq.push_back('{a: 32'h603, d: 8'hD4});
      set_base(32'h400);
      wr_cnt = 0;
      kick(1'b1, 1'b1);
      wait_idle();
      chk(!err_flag && done_flag, "R6", "link followed to end", {err_flag, done_flag}, 2'b01);
      chk(wr_cnt == 4 && wq.size() == 0, "R5", "writes from input stream", wr_cnt, 4);
      chk(in_q.size() == 0, "R5", "input stream drained", in_q.size(), 0);
      chk(mem[12'h900] == 8'h00, "R4", "skipped entries untouched", mem[12'h900], 0);
      pulse_clr(1'b0);

      // table C: one good entry then an invalid one
      err_ie = 1'b1;
      put_desc(12'h700, 8'h21, 16'd1, 32'h780);
      put_desc(12'h708, 8'h00, 16'd0, 32'h0);
      mem[12'h780] = 8'h5A;
      exp_out.push_back(8'h5A);
      set_base(32'h700);
      kick(1'b0, 1'b1);
      wait_idle();
      chk(err_flag && !done_flag, "R8", "error without done", {err_flag, done_flag}, 2'b10);
      chk(err_addr == 32'h708, "R8", "failing descriptor address", err_addr, 32'h708);
      chk(irq, "R8", "enabled error interrupt", irq, 1);
      chk(exp_out.size() == 0, "R8", "data before error delivered", exp_out.size(), 0);
      repeat (3) @(negedge clk);
      chk(err_flag, "R8", "error sticky", err_flag, 1);
      pulse_clr(1'b1);
      chk(!err_flag && !irq, "R8", "error cleared", {err_flag, irq}, 0);

      // gating: each enable removed in turn
      set_base(32'h100);
      rc = req_cnt;
      cfg_mode = 2'd1;
      kick(1'b0, 1'b1);
      repeat (6) @(negedge clk);
      chk(!busy && req_cnt == rc, "R2", "wrong mode ignored", req_cnt - rc, 0);
      cfg_mode = 2'd2;
      cfg_master_en = 1'b0;
      kick(1'b0, 1'b1);
      repeat (6) @(negedge clk);
      chk(!busy && req_cnt == rc, "R2", "master off ignored", req_cnt - rc, 0);
      cfg_master_en = 1'b1;
      kick(1'b0, 1'b0);
      repeat (6) @(negedge clk);
      chk(!busy && req_cnt == rc, "R2", "command dma off ignored", req_cnt - rc, 0);
      chk(!done_flag, "R2", "no completion when gated", done_flag, 0);

      // enabled rerun of table A
      exp_out = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      int_cnt = 0;
      kick(1'b0, 1'b1);
      wait_idle();
      chk(done_flag && exp_out.size() == 0, "R4", "rerun delivers all bytes",
          exp_out.size(), 0);
      chk(int_cnt == 1, "R9", "interrupt pulses on rerun", int_cnt, 1);

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule